// File: doc/BRIEF.md
# SONET Transmit Path Overhead Inserter

This block sits in the transmit datapath of one STS-1 path. It fills in the path overhead bytes as the byte stream passes. The upstream logic supplies each byte with three markers: a flag for bytes inside the synchronous payload envelope (SPE), a pulse on the first byte of every frame, and a two-bit code that marks the path trace, parity and status slots. The block puts the outgoing bytes on its output one clock later, with the markers delayed to match.

The trace slot carries one byte per frame from a 64-entry circular message store, which is written through a simple write port. The parity slot carries the even BIP-8 of the previous frame's SPE, taken over the bytes as they were actually sent. The status slot carries a remote error count and a remote defect indication. The defect indication comes either from three control bits or from a set of seven receive-side alarms, which it holds for at least 20 frames. One control bit replaces the whole SPE with all-ones, which is the path alarm indication signal.

An eight-bit control register holds all of these choices. It is written with `cfg_we` and takes the value 23h on reset.

Top module: `path_oh_inserter`

## Requirements
- R1: In a trace slot (code 1), the output is the message store entry at the read pointer when control bit 0 is 1. It is 00h when that bit is 0.
- R2: The read pointer starts at 0 after reset. It steps by one at every trace slot, whatever the control bits are, and wraps from 63 to 0.
- R3: In a parity slot (code 2), the output is the XOR of all output SPE bytes between the previous two frame-start pulses. It is 00h before the first full frame, and it is 00h when control bit 6 is 1.
- R4: In a status slot (code 3), bits 7..4 hold min(`rx_bip_errs`, 8) when control bit 5 is 1, and 0000 otherwise. The count is sampled in the cycle the status slot enters.
- R5: When control bit 7 is 0, status slot output bits 3, 2 and 1 copy control bits 3, 2 and 1. Bit 0 of the status byte is always 0.
- R6: When control bit 7 is 1, status bits 3..1 are 100 in each of the 20 frames that follow any frame in which an alarm input was high, and 000 otherwise. A new alarm frame restarts the 20-frame count.
- R7: When control bit 4 is 1, every SPE byte is sent as FFh, including the trace, parity and status slots.
- R8: Non-SPE bytes, and SPE bytes with code 0, pass through unchanged. All outputs follow their inputs with exactly one cycle of latency.
- R9: Reset clears `out_data`, `out_spe` and `out_fs` and loads the control register with 23h. The control register bits are: 0 trace enable, 1/2/3 manual defect bits, 4 alarm signal, 5 automatic error count, 6 parity zero, 7 automatic defect. A write takes effect from the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| tr_we | input | 1 | Trace message store write strobe |
| tr_waddr | input | 6 | Trace message store write address |
| tr_wdata | input | 8 | Trace message store write byte |
| in_data | input | 8 | Incoming byte |
| in_spe | input | 1 | Incoming byte lies inside the SPE |
| in_fs | input | 1 | First byte of a frame |
| in_poh | input | 2 | Slot code: 0 other, 1 trace, 2 parity, 3 status |
| rx_alarm | input | 7 | Receive-side alarm levels |
| rx_bip_errs | input | 4 | Received parity error count for this frame |
| out_data | output | 8 | Outgoing byte |
| out_spe | output | 1 | Delayed SPE flag |
| out_fs | output | 1 | Delayed frame-start pulse |

## Verification
The assertions assume that a nonzero slot code appears only on SPE bytes, and that the frame-start byte lies outside the SPE. They also take it that the parity slot never falls on the first two bytes of a frame. The stimulus builds every frame from one fixed twelve-byte layout: three overhead bytes, then the trace slot, parity slot and status slot at fixed SPE offsets. Control and message-store writes happen only on idle bytes between frames, so no write ever meets the entry or setting being read in the same cycle.

// File: rtl/poh_pkg.sv
// Shared definitions for the path overhead inserter.
// Assumes an eight-bit control register and a two-bit slot code.
package poh_pkg;
    typedef enum logic [1:0] {
        POS_NONE  = 2'd0,
        POS_TRACE = 2'd1,
        POS_BIP   = 2'd2,
        POS_STAT  = 2'd3
    } poh_pos_e;

    localparam int CB_TRACE_EN = 0;
    localparam int CB_RDI7     = 1;
    localparam int CB_RDI6     = 2;
    localparam int CB_RDI5     = 3;
    localparam int CB_AIS      = 4;
    localparam int CB_AUTO_REI = 5;
    localparam int CB_B3_ZERO  = 6;
    localparam int CB_AUTO_RDI = 7;

    localparam logic [7:0] CTRL_RST      = 8'h23;
    localparam logic [2:0] RDI_AUTO_CODE = 3'b100;
endpackage

// File: rtl/poh_trace_buf.sv
// Circular store for the path trace message.
// Reads are combinational at the read pointer. The pointer steps on adv and wraps at DEPTH-1.
// Assumes no write to the entry being read in the same cycle.
module poh_trace_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic                     adv,
    output logic [W-1:0]             rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;

    // store message bytes from the write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // step the read pointer once per trace slot, wrapping at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (adv) begin
            rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/poh_rdi_hold.sv
// Frame-based hold for the automatic remote defect indication.
// Any alarm seen during a frame loads HOLD at the next frame start.
// The count then falls by one per alarm-free frame.
// Assumes frame_start is a one-cycle pulse per frame.
module poh_rdi_hold #(
    parameter int HOLD     = 20,
    parameter int N_ALARMS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [N_ALARMS-1:0] alarm,
    output logic                rdi
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;
    logic          seen;

    // collect alarms per frame and update the hold count at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (frame_start) begin
            cnt  <= seen ? CW'(HOLD) : ((cnt != '0) ? cnt - CW'(1) : cnt);
            seen <= |alarm;
        end else begin
            seen <= seen | (|alarm);
        end
    end

    assign rdi = (cnt != '0);
endmodule

// File: rtl/poh_bip_acc.sv
// Even-parity BIP accumulator over the bytes of one frame.
// At each frame start, the finished result moves to bip and a new sum begins.
// The frame-start byte itself counts toward the new frame.
module poh_bip_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] bip
);
    logic [W-1:0] acc;
    logic [W-1:0] term;

    assign term = byte_vld ? byte_in : '0;

    // accumulate bit-interleaved parity and close it at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            bip <= '0;
        end else if (frame_start) begin
            bip <= acc;
            acc <= term;
        end else begin
            acc <= acc ^ term;
        end
    end
endmodule

// File: rtl/path_oh_inserter.sv
// Transmit path overhead inserter for one STS-1 path.
// Fills the trace, parity and status slots of the byte stream and can force all-ones on the SPE.
// Assumes slot codes appear only on SPE bytes and frame start lies outside the SPE.
// Output latency is one cycle.
module path_oh_inserter
    import poh_pkg::*;
#(
    parameter int TRACE_DEPTH = 64,
    parameter int HOLD_FRAMES = 20,
    parameter int N_ALARMS    = 7,
    parameter int ERR_W       = 4,
    parameter int REI_MAX     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [7:0]                     cfg_wdata,
    input  logic                           tr_we,
    input  logic [$clog2(TRACE_DEPTH)-1:0] tr_waddr,
    input  logic [7:0]                     tr_wdata,
    input  logic [7:0]                     in_data,
    input  logic                           in_spe,
    input  logic                           in_fs,
    input  logic [1:0]                     in_poh,
    input  logic [N_ALARMS-1:0]            rx_alarm,
    input  logic [ERR_W-1:0]               rx_bip_errs,
    output logic [7:0]                     out_data,
    output logic                           out_spe,
    output logic                           out_fs
);
    logic [7:0]       ctrl_q;
    poh_pos_e         pos;
    logic             is_trace;
    logic [7:0]       trace_byte;
    logic             rdi_auto;
    logic [7:0]       bip_prev;
    logic [ERR_W-1:0] errs_sat;
    logic [3:0]       rei_nib;
    logic [2:0]       rdi_bits;
    logic [7:0]       nxt_data;

    // control register with its reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (cfg_we) begin
            ctrl_q <= cfg_wdata;
        end
    end

    assign pos      = poh_pos_e'(in_poh);
    assign is_trace = in_spe && (pos == POS_TRACE);

    poh_trace_buf #(
        .DEPTH (TRACE_DEPTH),
        .W     (8)
    ) u_trace (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tr_we),
        .wr_addr (tr_waddr),
        .wr_data (tr_wdata),
        .adv     (is_trace),
        .rd_data (trace_byte)
    );

    poh_rdi_hold #(
        .HOLD     (HOLD_FRAMES),
        .N_ALARMS (N_ALARMS)
    ) u_rdi (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (in_fs),
        .alarm       (rx_alarm),
        .rdi         (rdi_auto)
    );

    poh_bip_acc #(
        .W (8)
    ) u_bip (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (in_fs),
        .byte_vld    (in_spe),
        .byte_in     (nxt_data),
        .bip         (bip_prev)
    );

    assign errs_sat = (rx_bip_errs > ERR_W'(REI_MAX)) ? ERR_W'(REI_MAX) : rx_bip_errs;
    assign rei_nib  = ctrl_q[CB_AUTO_REI] ? errs_sat[3:0] : 4'd0;
    assign rdi_bits = ctrl_q[CB_AUTO_RDI]
                      ? (rdi_auto ? RDI_AUTO_CODE : 3'b000)
                      : {ctrl_q[CB_RDI5], ctrl_q[CB_RDI6], ctrl_q[CB_RDI7]};

    // choose the outgoing byte for the current slot
    always_comb begin
        nxt_data = in_data;
        if (in_spe) begin
            if (ctrl_q[CB_AIS]) begin
                nxt_data = 8'hFF;
            end else begin
                case (pos)
                    POS_TRACE: nxt_data = ctrl_q[CB_TRACE_EN] ? trace_byte : 8'h00;
                    POS_BIP:   nxt_data = ctrl_q[CB_B3_ZERO] ? 8'h00 : bip_prev;
                    POS_STAT:  nxt_data = {rei_nib, rdi_bits, 1'b0};
                    default:   nxt_data = in_data;
                endcase
            end
        end
    end

    // output register stage with its markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= 8'h00;
            out_spe  <= 1'b0;
            out_fs   <= 1'b0;
        end else begin
            out_data <= nxt_data;
            out_spe  <= in_spe;
            out_fs   <= in_fs;
        end
    end
endmodule

// File: rtl/path_oh_chk.sv
// Checker for path_oh_inserter, bound to every instance.
// Relates the outgoing bytes to the incoming slot markers and control one cycle earlier.
module path_oh_chk
    import poh_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] in_data,
    input logic       in_spe,
    input logic       in_fs,
    input logic [1:0] in_poh,
    input logic [7:0] ctrl,
    input logic [7:0] out_data,
    input logic       out_spe,
    input logic       out_fs
);
    logic ok_q;

    // marks cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        ok_q <= rst_n;
    end

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(!in_spe)) |-> (out_data == $past(in_data) && !out_spe));

    // R8
    fs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q |-> (out_fs == $past(in_fs)));

    // R7
    ais_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(in_spe && ctrl[CB_AIS])) |-> (out_data == 8'hFF));

    // R1
    trace_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(in_spe && in_poh == POS_TRACE && !ctrl[CB_AIS] && !ctrl[CB_TRACE_EN]))
        |-> (out_data == 8'h00));

    // R3
    bip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(in_spe && in_poh == POS_BIP && !ctrl[CB_AIS] && ctrl[CB_B3_ZERO]))
        |-> (out_data == 8'h00));

    // R4
    rei_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(in_spe && in_poh == POS_STAT && !ctrl[CB_AIS]))
        |-> (out_data[7:4] <= 4'd8 && !out_data[0]));

    // R5
    rdi_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(in_spe && in_poh == POS_STAT && !ctrl[CB_AIS] && !ctrl[CB_AUTO_RDI]))
        |-> (out_data[3:1] == $past(ctrl[3:1])));

    // R6
    rdi_auto_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && $past(in_spe && in_poh == POS_STAT && !ctrl[CB_AIS] && ctrl[CB_AUTO_RDI]))
        |-> (out_data[2:1] == 2'b00));
endmodule

bind path_oh_inserter path_oh_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_spe   (in_spe),
    .in_fs    (in_fs),
    .in_poh   (in_poh),
    .ctrl     (ctrl_q),
    .out_data (out_data),
    .out_spe  (out_spe),
    .out_fs   (out_fs)
);

// File: tb/tb_path_oh_inserter.sv
module tb_path_oh_inserter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       tr_we;
    logic [5:0] tr_waddr;
    logic [7:0] tr_wdata;
    logic [7:0] in_data;
    logic       in_spe;
    logic       in_fs;
    logic [1:0] in_poh;
    logic [6:0] rx_alarm;
    logic [3:0] rx_bip_errs;
    logic [7:0] out_data;
    logic       out_spe;
    logic       out_fs;

    always #5 clk = ~clk;

    path_oh_inserter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tr_we(tr_we), .tr_waddr(tr_waddr), .tr_wdata(tr_wdata),
        .in_data(in_data), .in_spe(in_spe), .in_fs(in_fs), .in_poh(in_poh),
        .rx_alarm(rx_alarm), .rx_bip_errs(rx_bip_errs),
        .out_data(out_data), .out_spe(out_spe), .out_fs(out_fs)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int frame_no = 0;

    logic [7:0] m_ctrl;
    logic [7:0] m_tbuf [64];
    logic [7:0] m_acc;
    logic [7:0] m_prev;
    int         m_ptr;
    int         m_cnt;
    bit         m_seen;
    logic [7:0] last_g1;

    // {ctrl, error count, expected status byte}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        20'h23002, 20'h23332, 20'h23882, 20'h23F82, 20'h03502,
        20'h2F11E, 20'h29228, 20'h65984, 20'h20440, 20'h310FF
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        in_data = 8'h00; in_spe = 1'b0; in_fs = 1'b0; in_poh = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        tr_we  = 1'b0;
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        idle_cycle();
        m_ctrl = v;
    endtask

    task automatic model_reset();
        m_ctrl = 8'h23; m_acc = 8'h00; m_prev = 8'h00;
        m_ptr = 0; m_cnt = 0; m_seen = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_cycle();
        idle_cycle();
        check8("R9 reset out_data", out_data, 8'h00);
        check8("R9 reset markers", {6'd0, out_spe, out_fs}, 8'h00);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic run_frame(input logic [6:0] alarm, input logic [3:0] errs);
        logic [7:0] e;
        logic [3:0] rei;
        logic [2:0] rdi;
        string      req;
        rx_alarm = alarm;
        rx_bip_errs = errs;
        if (m_seen) m_cnt = 20; else if (m_cnt > 0) m_cnt--;
        m_seen = |alarm;
        m_prev = m_acc;
        m_acc  = 8'h00;
        for (int idx = 0; idx < 12; idx++) begin
            in_spe  = (idx >= 3);
            in_fs   = (idx == 0);
            in_poh  = (idx == 3) ? 2'd1 : (idx == 5) ? 2'd2 : (idx == 7) ? 2'd3 : 2'd0;
            in_data = 8'((frame_no * 13 + idx * 7 + 5) & 255);
            req = (idx == 3) ? "R1_R2 trace" : (idx == 5) ? "R3 parity" :
                  (idx == 7) ? "R4_R5_R6 status" : "R8 passthrough";
            if (!in_spe) e = in_data;
            else if (m_ctrl[4]) begin e = 8'hFF; req = "R7 alarm fill"; end
            else if (idx == 3) e = m_ctrl[0] ? m_tbuf[m_ptr] : 8'h00;
            else if (idx == 5) e = m_ctrl[6] ? 8'h00 : m_prev;
            else if (idx == 7) begin
                rei = m_ctrl[5] ? ((errs > 4'd8) ? 4'd8 : errs) : 4'd0;
                rdi = m_ctrl[7] ? ((m_cnt != 0) ? 3'b100 : 3'b000) : m_ctrl[3:1];
                e = {rei, rdi, 1'b0};
            end else e = in_data;
            @(negedge clk);
            check8(req, out_data, e);
            if (idx == 0) check8("R8 markers fs", {6'd0, out_spe, out_fs}, 8'h01);
            if (idx == 3) check8("R8 markers spe", {6'd0, out_spe, out_fs}, 8'h02);
            if (in_spe) m_acc = m_acc ^ e;
            if (idx == 3) m_ptr = (m_ptr + 1) % 64;
            if (idx == 7) last_g1 = out_data;
        end
        frame_no++;
        idle_cycle();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt_rdi;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; tr_we = 1'b0;
        tr_waddr = 6'd0; tr_wdata = 8'h00; rx_alarm = 7'd0; rx_bip_errs = 4'd0;
        in_data = 8'h00; in_spe = 1'b0; in_fs = 1'b0; in_poh = 2'd0;
        @(negedge clk);
        do_reset();

        // fill the trace store
        for (int i = 0; i < 64; i++) begin
            m_tbuf[i] = 8'((i * 5 + 3) & 255);
            tr_we = 1'b1; tr_waddr = 6'(i); tr_wdata = m_tbuf[i];
            idle_cycle();
        end

        // R9 default control after reset: trace on, manual bit on status bit 1, auto count on
        run_frame(7'd0, 4'd6);
        check8("R9 default status", last_g1, 8'h62);

        // table walk: R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            write_ctrl(VEC[v][19:12]);
            run_frame(7'd0, VEC[v][11:8]);
            check8("R4_R5_R7 table status", last_g1, VEC[v][7:0]);
        end

        // R6 hold length after a single alarm frame
        write_ctrl(8'hA1);
        run_frame(7'd0, 4'd0);
        run_frame(7'h01, 4'd0);
        check8("R6 no defect in alarm frame", {7'd0, last_g1[3]}, 8'h00);
        cnt_rdi = 0;
        for (int f = 0; f < 25; f++) begin
            run_frame(7'd0, 4'd0);
            if (last_g1[3]) cnt_rdi++;
        end
        check8("R6 hold frames", 8'(cnt_rdi), 8'd20);

        // R6 restart on a second alarm
        run_frame(7'h40, 4'd0);
        for (int f = 0; f < 10; f++) run_frame(7'd0, 4'd0);
        run_frame(7'h08, 4'd0);
        cnt_rdi = 0;
        for (int f = 0; f < 25; f++) begin
            run_frame(7'd0, 4'd0);
            if (last_g1[3]) cnt_rdi++;
        end
        check8("R6 restart hold frames", 8'(cnt_rdi), 8'd20);

        // R6 each alarm input on its own
        for (int b = 0; b < 7; b++) begin
            run_frame(7'(1 << b), 4'd0);
            run_frame(7'd0, 4'd0);
            check8("R6 single alarm", {7'd0, last_g1[3]}, 8'h01);
            for (int f = 0; f < 20; f++) run_frame(7'd0, 4'd0);
            check8("R6 released", {7'd0, last_g1[3]}, 8'h00);
        end

        // R2 wrap: more than a full pass through the message store
        write_ctrl(8'h21);
        for (int f = 0; f < 70; f++) run_frame(7'd0, 4'd1);

        // R3 parity zero and R1 trace off, then back on
        write_ctrl(8'h60);
        run_frame(7'd0, 4'd2);
        write_ctrl(8'h21);
        run_frame(7'd0, 4'd2);
        run_frame(7'd0, 4'd2);

        // R9 reset in mid-run restores control and pointer
        write_ctrl(8'h5C);
        run_frame(7'd0, 4'd3);
        do_reset();
        run_frame(7'd0, 4'd5);
        check8("R9 control back to default", last_g1, 8'h52);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule